// File: doc/BRIEF.md
# Floating-Point Result Packer (binary32 / binary64)

This block takes a floating-point value held in a wide internal form and turns it into an IEEE-754 word. The internal form has five parts: a class, a sign, an unbiased signed exponent, a significand whose explicit leading one sits in the top bit, and a sticky bit that summarises the bits already lost below that significand. A select input chooses whether the result is binary32 or binary64. The block adds the format's exponent bias. It shifts values that are too small into the subnormal range and rounds the kept significand under one of four rounding modes. When the rounded exponent leaves the finite range, the result saturates to infinity or to the largest finite value, as the rounding mode decides.

The block has a single register stage. A value offered with `in_valid` high appears on the output one clock later with `out_valid` set, together with three status bits: overflow, underflow and inexact. A NaN keeps the upper bits of its payload and always comes out quiet. An arithmetic pipeline places this block at its write-back end to produce architectural register images from its internal results.

Top module: `fpk_packer`

## Requirements
- R1: With `in_dbl`=0 the result is binary32 with bias 127 and 23 fraction bits, placed in `out_bits[31:0]` with `out_bits[63:32]` zero. With `in_dbl`=1 it is binary64 with bias 1023 and 52 fraction bits in `out_bits[63:0]`.
- R2: The class encoding is 0 zero, 1 finite number, 2 infinity, 3 NaN. A zero packs as the sign alone. An infinity packs as the sign, an all-ones exponent and a zero fraction. Neither class raises any status bit.
- R3: A NaN packs with an all-ones exponent. Its fraction is taken from the significand bits directly below the leading-one position (top bit first), and the fraction's top bit (the quiet bit) is forced to 1.
- R4: The rounding-mode encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. Round-to-nearest breaks a tie toward an even last bit. `out_inx` is set whenever any discarded bit or the sticky input is nonzero.
- R5: For a normal result, a round-up that carries out of the significand raises the exponent by one and leaves a zero fraction.
- R6: A biased exponent of 0 or below takes the subnormal path. The significand is shifted right by (1 - biased exponent) further places, with the shifted-out bits folded into the sticky, before rounding. The exponent field of the result is 0.
- R7: A subnormal that rounds up into the leading-one position becomes the smallest normal (exponent field 1, fraction 0), and `out_unf` stays clear.
- R8: A result that stays subnormal sets `out_unf` only when the rounding was inexact or `unf_trap_en` is 1.
- R9: A finite number whose biased exponent after rounding is 255 or more (binary32) or 2047 or more (binary64) is an overflow. Every overflow sets both `out_ovf` and `out_inx`.
- R10: On overflow the result is infinity under nearest-even, under toward +infinity with sign 0, and under toward -infinity with sign 1. Otherwise it is the largest finite value: exponent field one below all ones, fraction all ones, with the input sign.
- R11: Results and status bits appear exactly one clock after the input cycle, with `out_valid` following `in_valid`. A synchronous reset clears `out_valid`, `out_bits` and all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value is present this cycle |
| in_dbl | input | 1 | 0 selects binary32, 1 selects binary64 |
| in_class | input | 2 | Value class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W (13) | Unbiased exponent, two's complement |
| in_mant | input | MANT_W (64) | Significand, leading one at the top bit |
| in_sticky | input | 1 | OR of bits already lost below `in_mant` |
| rnd_mode | input | 2 | Rounding mode (see R4) |
| unf_trap_en | input | 1 | Underflow trap enable, widens the underflow report |
| out_valid | output | 1 | Result present |
| out_bits | output | 64 | Packed IEEE-754 word |
| out_ovf | output | 1 | Overflow status |
| out_unf | output | 1 | Underflow status |
| out_inx | output | 1 | Inexact status |

## Verification
Two pairs of functions can fire in the same cycle. The first pair is the rounding carry and the range limit. An all-ones significand at the top normal exponent rounds up, carries into the exponent, and that same carry pushes the exponent into overflow. The bench expects the saturated value and both `out_ovf` and `out_inx`. The second pair is promotion and underflow reporting: a subnormal at biased exponent 0 with an all-ones significand rounds into the smallest normal while `unf_trap_en` is high. The bench expects exponent field 1 and a clear `out_unf`. Each expected word is worked out by hand from the requirements and compared through a scoreboard queue as results leave the pipeline.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_e;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TO_ZERO   = 2'd1,
        RND_TO_POS    = 2'd2,
        RND_TO_NEG    = 2'd3
    } rnd_mode_e;

    localparam int SGL_FRAC = 23;
    localparam int DBL_FRAC = 52;
    localparam int SGL_BIAS = 127;
    localparam int DBL_BIAS = 1023;
    localparam int SGL_EMAX = 255;
    localparam int DBL_EMAX = 2047;
    localparam int SIG_W    = DBL_FRAC + 1;   // widest kept significand

    typedef struct packed {
        logic [63:0] bits;
        logic        ovf;
        logic        unf;
        logic        inx;
    } pk_result_t;

    // Decide whether the kept significand is bumped by one unit.
    function automatic logic rnd_bump(rnd_mode_e mode, logic sign,
                                      logic lsb, logic guard, logic rest);
        logic lost;
        lost = guard | rest;
        case (mode)
            RND_NEAR_EVEN: rnd_bump = guard & (rest | lsb);
            RND_TO_ZERO:   rnd_bump = 1'b0;
            RND_TO_POS:    rnd_bump = lost & ~sign;
            default:       rnd_bump = lost & sign;
        endcase
    endfunction

    // On overflow: saturate to infinity (1) or to the largest finite value (0).
    function automatic logic sat_to_inf(rnd_mode_e mode, logic sign);
        case (mode)
            RND_NEAR_EVEN: sat_to_inf = 1'b1;
            RND_TO_ZERO:   sat_to_inf = 1'b0;
            RND_TO_POS:    sat_to_inf = ~sign;
            default:       sat_to_inf = sign;
        endcase
    endfunction

    // Assemble a word; binary32 lands in the low half.
    function automatic logic [63:0] pack_word(logic dbl, logic sign,
                                              logic [10:0] efield,
                                              logic [DBL_FRAC-1:0] frac);
        if (dbl)
            pack_word = {sign, efield, frac};
        else
            pack_word = {32'd0, sign, efield[7:0], frac[SGL_FRAC-1:0]};
    endfunction

endpackage

// File: rtl/fpk_align.sv
module fpk_align
    import fpk_pkg::*;
#(
    parameter int MANT_W = 64,
    localparam int SHW   = $clog2(MANT_W + 1)
) (
    input  logic [MANT_W-1:0] mant,
    input  logic              sticky_in,
    input  logic [SHW-1:0]    shamt,
    input  logic              dbl,
    output logic [SIG_W-1:0]  sig,
    output logic              guard,
    output logic              rest
);
    localparam int SGL_SIG = SGL_FRAC + 1;
    localparam int DBL_SIG = DBL_FRAC + 1;

    logic [MANT_W-1:0] shifted;
    logic              lost;

    always_comb begin
        shifted = mant >> shamt;
        lost    = |(mant & ~({MANT_W{1'b1}} << shamt));
    end

    always_comb begin
        assert (shamt <= SHW'(MANT_W))   // R6 shift count stays within the capped range
            else $error("AST_SHAMT_CAP violated");
    end

    always_comb begin
        if (dbl) begin
            sig   = shifted[MANT_W-1 -: DBL_SIG];
            guard = shifted[MANT_W-DBL_SIG-1];
            rest  = (|shifted[MANT_W-DBL_SIG-2:0]) | lost | sticky_in;
        end else begin
            sig   = {{(SIG_W-SGL_SIG){1'b0}}, shifted[MANT_W-1 -: SGL_SIG]};
            guard = shifted[MANT_W-SGL_SIG-1];
            rest  = (|shifted[MANT_W-SGL_SIG-2:0]) | lost | sticky_in;
        end
    end

endmodule

// File: rtl/fpk_round.sv
module fpk_round
    import fpk_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  logic             guard,
    input  logic             rest,
    input  logic             sign,
    input  rnd_mode_e        mode,
    output logic [SIG_W:0]   sig_rnd,
    output logic             inexact
);
    logic bump;

    always_comb begin
        inexact = guard | rest;
        bump    = rnd_bump(mode, sign, sig[0], guard, rest);
        sig_rnd = {1'b0, sig} + {{SIG_W{1'b0}}, bump};
    end

endmodule

// File: rtl/fpk_packer.sv
module fpk_packer
    import fpk_pkg::*;
#(
    parameter int EXP_W  = 13,
    parameter int MANT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_dbl,
    input  logic [1:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        rnd_mode,
    input  logic              unf_trap_en,
    output logic              out_valid,
    output logic [63:0]       out_bits,
    output logic              out_ovf,
    output logic              out_unf,
    output logic              out_inx
);
    localparam int EW  = EXP_W + 1;
    localparam int SHW = $clog2(MANT_W + 1);
    localparam logic signed [EW-1:0] MANT_LIM = EW'(MANT_W);

    fp_class_e cls;
    rnd_mode_e mode;
    assign cls  = fp_class_e'(in_class);
    assign mode = rnd_mode_e'(rnd_mode);

    // Bias and subnormal shift
    logic signed [EW-1:0] be, neg;
    logic                 sub;
    logic [SHW-1:0]       shamt;

    always_comb begin
        be  = $signed({in_exp[EXP_W-1], in_exp})
            + (in_dbl ? EW'(DBL_BIAS) : EW'(SGL_BIAS));
        sub = (be <= 0);
        neg = EW'(1) - be;
        if (!sub)
            shamt = '0;
        else if (neg > MANT_LIM)
            shamt = SHW'(MANT_W);
        else
            shamt = neg[SHW-1:0];
    end

    logic [SIG_W-1:0] sig;
    logic             guard, rest;
    logic [SIG_W:0]   sig_rnd;
    logic             inexact;

    fpk_align #(.MANT_W(MANT_W)) u_align (
        .mant      (in_mant),
        .sticky_in (in_sticky),
        .shamt     (shamt),
        .dbl       (in_dbl),
        .sig       (sig),
        .guard     (guard),
        .rest      (rest)
    );

    fpk_round u_round (
        .sig     (sig),
        .guard   (guard),
        .rest    (rest),
        .sign    (in_sign),
        .mode    (mode),
        .sig_rnd (sig_rnd),
        .inexact (inexact)
    );

    // Exponent after rounding, range check and assembly
    logic                 carry, hidden, ovf;
    logic signed [EW-1:0] e_fin, e_max;
    logic [DBL_FRAC-1:0]  frac, nan_frac;
    pk_result_t           res;

    always_comb begin
        carry  = in_dbl ? sig_rnd[DBL_FRAC+1] : sig_rnd[SGL_FRAC+1];
        hidden = in_dbl ? sig_rnd[DBL_FRAC]   : sig_rnd[SGL_FRAC];
        e_max  = in_dbl ? EW'(DBL_EMAX) : EW'(SGL_EMAX);
        e_fin  = sub ? (hidden ? EW'(1) : EW'(0)) : be + EW'(carry);
        frac   = in_dbl ? sig_rnd[DBL_FRAC-1:0]
                        : {{(DBL_FRAC-SGL_FRAC){1'b0}}, sig_rnd[SGL_FRAC-1:0]};
        nan_frac = in_dbl
            ? {1'b1, in_mant[MANT_W-3 -: DBL_FRAC-1]}
            : {{(DBL_FRAC-SGL_FRAC){1'b0}}, 1'b1, in_mant[MANT_W-3 -: SGL_FRAC-1]};
        ovf    = !sub && (e_fin >= e_max);

        res = '0;
        case (cls)
            CLS_ZERO: res.bits = pack_word(in_dbl, in_sign, 11'd0, '0);
            CLS_INF:  res.bits = pack_word(in_dbl, in_sign, e_max[10:0], '0);
            CLS_NAN:  res.bits = pack_word(in_dbl, in_sign, e_max[10:0], nan_frac);
            default: begin
                res.ovf = ovf;
                res.inx = inexact | ovf;
                res.unf = sub && !hidden && (inexact || unf_trap_en);
                if (!ovf)
                    res.bits = pack_word(in_dbl, in_sign, e_fin[10:0], frac);
                else if (sat_to_inf(mode, in_sign))
                    res.bits = pack_word(in_dbl, in_sign, e_max[10:0], '0);
                else
                    res.bits = pack_word(in_dbl, in_sign, e_max[10:0] - 11'd1, '1);
            end
        endcase
    end

    // Output stage
    logic      dbl_q;
    fp_class_e cls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
            out_ovf   <= 1'b0;
            out_unf   <= 1'b0;
            out_inx   <= 1'b0;
            dbl_q     <= 1'b0;
            cls_q     <= CLS_ZERO;
        end else begin
            out_valid <= in_valid;
            out_bits  <= res.bits;
            out_ovf   <= res.ovf;
            out_unf   <= res.unf;
            out_inx   <= res.inx;
            dbl_q     <= in_dbl;
            cls_q     <= cls;
        end
    end

    logic [10:0] ef_q;
    assign ef_q = dbl_q ? out_bits[62:52] : {3'd0, out_bits[30:23]};

    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && !dbl_q |-> out_bits[63:32] == 32'd0);   // R1
    AST_SPECIAL_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        out_valid && cls_q != CLS_NUM |-> !out_ovf && !out_unf && !out_inx);   // R2
    AST_UNF_EXP_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_unf |-> ef_q == 11'd0 && !out_ovf);   // R8
    AST_OVF_SAT_EXP: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> ef_q >= (dbl_q ? 11'd2046 : 11'd254));   // R10
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> out_inx);   // R9
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);   // R11
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);   // R11

endmodule

// File: tb/test_fpk_packer.sv
module test_fpk_packer;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_dbl, in_sign, in_sticky, unf_trap_en;
    logic [1:0]  in_class, rnd_mode;
    logic [12:0] in_exp;
    logic [63:0] in_mant;
    logic        out_valid, out_ovf, out_unf, out_inx;
    logic [63:0] out_bits;

    always #4 clk = ~clk;   // 125 MHz

    fpk_packer i_fpk_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_class(in_class), .in_sign(in_sign), .in_exp(in_exp),
        .in_mant(in_mant), .in_sticky(in_sticky), .rnd_mode(rnd_mode),
        .unf_trap_en(unf_trap_en), .out_valid(out_valid), .out_bits(out_bits),
        .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
    );

    typedef struct {
        logic [63:0] bits;
        logic        ovf, unf, inx;
        string       tag;
    } exp_item_t;

    exp_item_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

    task automatic send(input logic dbl, input logic [1:0] cls, input logic s,
                        input int e, input logic [63:0] m, input logic stk,
                        input logic [1:0] rm, input logic trap,
                        input logic [63:0] eb, input logic eo, input logic eu,
                        input logic ei, input string tag);
        exp_item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_class = cls; in_sign = s;
        in_exp = 13'(e); in_mant = m; in_sticky = stk; rnd_mode = rm;
        unf_trap_en = trap;
        it.bits = eb; it.ovf = eo; it.unf = eu; it.inx = ei; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pop and compare as results leave the pipeline
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R11: unexpected out_valid, bits=%h expected no result", out_bits);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                if (out_bits !== it.bits || out_ovf !== it.ovf ||
                    out_unf !== it.unf || out_inx !== it.inx) begin
                    fails++;
                    $display("FAIL %s: bits=%h o/u/i=%b%b%b expected bits=%h o/u/i=%b%b%b",
                             it.tag, out_bits, out_ovf, out_unf, out_inx,
                             it.bits, it.ovf, it.unf, it.inx);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_dbl = 0; in_class = 0; in_sign = 0;
        in_exp = 0; in_mant = 0; in_sticky = 0; rnd_mode = 0; unf_trap_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        checks++;
        if (out_valid !== 1'b0 || out_bits !== 64'd0 || out_ovf || out_unf || out_inx) begin
            fails++;
            $display("FAIL R11: reset state valid=%b bits=%h expected 0/0", out_valid, out_bits);
        end

        // R1 basic format and placement
        send(0, 1, 0,    0, ONE, 0, 0, 0, 64'h0000_0000_3F80_0000, 0, 0, 0, "R1 single 1.0");
        send(1, 1, 0,    0, ONE, 0, 0, 0, 64'h3FF0_0000_0000_0000, 0, 0, 0, "R1 double 1.0");
        // R2 zero and infinity
        send(0, 0, 1,    5, ONE, 1, 0, 1, 64'h0000_0000_8000_0000, 0, 0, 0, "R2 single -0");
        send(1, 0, 1,    0, 0,   0, 0, 0, 64'h8000_0000_0000_0000, 0, 0, 0, "R2 double -0");
        send(0, 2, 0,    0, ONE, 0, 0, 0, 64'h0000_0000_7F80_0000, 0, 0, 0, "R2 single +inf");
        // R3 NaN payload and quiet bit
        send(0, 3, 0,    0, 64'hA000_0000_0000_0000, 0, 0, 0, 64'h0000_0000_7FE0_0000, 0, 0, 0, "R3 single nan");
        send(1, 3, 1,    0, 64'hA000_0000_0000_0000, 0, 0, 0, 64'hFFFC_0000_0000_0000, 0, 0, 0, "R3 double nan");
        send(0, 3, 0,    0, ONE, 0, 0, 0, 64'h0000_0000_7FC0_0000, 0, 0, 0, "R3 signalling made quiet");
        // R4 rounding modes
        send(0, 1, 0,    0, 64'h8000_0080_0000_0000, 0, 0, 0, 64'h0000_0000_3F80_0000, 0, 0, 1, "R4 tie to even down");
        send(0, 1, 0,    0, 64'h8000_0180_0000_0000, 0, 0, 0, 64'h0000_0000_3F80_0002, 0, 0, 1, "R4 tie to even up");
        send(0, 1, 0,    0, 64'h8000_0180_0000_0000, 0, 1, 0, 64'h0000_0000_3F80_0001, 0, 0, 1, "R4 toward zero");
        send(0, 1, 0,    0, 64'h8000_0180_0000_0000, 0, 2, 0, 64'h0000_0000_3F80_0002, 0, 0, 1, "R4 toward +inf pos");
        send(0, 1, 0,    0, 64'h8000_0180_0000_0000, 0, 3, 0, 64'h0000_0000_3F80_0001, 0, 0, 1, "R4 toward -inf pos");
        send(0, 1, 1,    0, 64'h8000_0180_0000_0000, 0, 3, 0, 64'h0000_0000_BF80_0002, 0, 0, 1, "R4 toward -inf neg");
        send(0, 1, 0,    0, ONE, 1, 2, 0, 64'h0000_0000_3F80_0001, 0, 0, 1, "R4 sticky only");
        send(1, 1, 0,    0, 64'h8000_0000_0000_0C00, 0, 0, 0, 64'h3FF0_0000_0000_0002, 0, 0, 1, "R4 double round");
        // R5 carry into exponent
        send(0, 1, 0,    0, ALL1, 0, 0, 0, 64'h0000_0000_4000_0000, 0, 0, 1, "R5 carry to 2.0");
        // R6 / R8 subnormals
        send(0, 1, 0, -127, ONE, 0, 0, 0, 64'h0000_0000_0040_0000, 0, 0, 0, "R6 exact subnormal no trap");
        send(0, 1, 0, -127, ONE, 0, 0, 1, 64'h0000_0000_0040_0000, 0, 1, 0, "R8 exact subnormal trap on");
        send(0, 1, 0, -149, ONE, 0, 0, 0, 64'h0000_0000_0000_0001, 0, 0, 0, "R6 smallest subnormal");
        send(0, 1, 0, -150, ONE, 0, 0, 0, 64'h0000_0000_0000_0000, 0, 1, 1, "R8 tie rounds to zero");
        send(1, 1, 0, -1023, ONE, 0, 0, 1, 64'h0008_0000_0000_0000, 0, 1, 0, "R6 double subnormal");
        send(1, 1, 0, -4000, ONE, 0, 2, 0, 64'h0000_0000_0000_0001, 0, 1, 1, "R6 deep shift sticky");
        // R7 promotion to smallest normal, trap enabled
        send(0, 1, 0, -127, ALL1, 0, 0, 1, 64'h0000_0000_0080_0000, 0, 0, 1, "R7 promote single");
        send(1, 1, 1, -1023, ALL1, 0, 0, 0, 64'h8010_0000_0000_0000, 0, 0, 1, "R7 promote double");
        // R9 / R10 overflow
        send(0, 1, 0,  128, ONE, 0, 0, 0, 64'h0000_0000_7F80_0000, 1, 0, 1, "R9 single overflow nearest");
        send(0, 1, 0,  127, ALL1, 0, 0, 0, 64'h0000_0000_7F80_0000, 1, 0, 1, "R9 overflow by rounding carry");
        send(0, 1, 0,  128, ONE, 0, 1, 0, 64'h0000_0000_7F7F_FFFF, 1, 0, 1, "R10 toward zero max finite");
        send(0, 1, 1,  128, ONE, 0, 2, 0, 64'h0000_0000_FF7F_FFFF, 1, 0, 1, "R10 +inf mode negative");
        send(0, 1, 1,  128, ONE, 0, 3, 0, 64'h0000_0000_FF80_0000, 1, 0, 1, "R10 -inf mode negative");
        send(1, 1, 1, 1024, ONE, 0, 1, 0, 64'hFFEF_FFFF_FFFF_FFFF, 1, 0, 1, "R10 double max finite");
        send(1, 1, 0, 1023, ONE, 0, 0, 0, 64'h7FE0_0000_0000_0000, 0, 0, 0, "R9 double top normal");
        idle();
        idle();
        // R11 a bubble then one more value
        send(0, 1, 0,    1, ONE, 0, 0, 0, 64'h0000_0000_4000_0000, 0, 0, 0, "R11 after bubble");
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R11: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule